// File: doc/BRIEF.md
# Trigger-Mode Host Watchdog with Drive Gating

This block supervises a host processor that must toggle a trigger line at a steady rhythm. After reset, or whenever monitoring is switched on, the block opens a long start-up window in which the host has time to boot. The first valid trigger, or the end of that window, starts a repeating service period. Each period is a closed window, in which a trigger is too early, followed by an open window, in which a trigger is expected. Early triggers and missed periods raise a saturating fail count. Well-timed triggers lower it and mark the host as having serviced the watchdog correctly at least once.

Software owns a drive-enable bit that reaches an external output, typically a gate for safety-relevant actuators. The watchdog never sets that bit. It only decides whether a software write of 1 is accepted, and it force-clears the bit when the fail count passes a programmable threshold. Faults are reported through sticky flags and an active-low interrupt line. No reset output is ever driven. Monitoring can be stopped by an external disable pin or by a register bit, and a hold bit keeps the watchdog parked in the start-up window.

The register port has two addresses. Address 0 is control: bit 0 turns monitoring on (reset value 1), bit 1 is hold (reset 0), bit 2 is the drive request (it reads back the actual drive state), and bits 6:4 hold the fail threshold (reset 3). Address 1 is status: bit 0 is the fail flag and bit 1 the start-up timeout flag, both cleared by writing 1. Bit 2 is the first-good flag and bits 6:4 the fail count, both read-only.

Top module: `trig_wdog`

## Requirements
- R1: After reset, en_drv is 0, int_n is 1, fail_cnt is 0, first_ok is 0 and in_long is 1.
- R2: While in_long is 1, en_drv stays 0 and a drive request write has no effect. If LONG_CYC cycles pass with no accepted trigger, fail_cnt rises by 1, the timeout flag (status bit 1) is set, int_n goes low and in_long drops.
- R3: With hold (control bit 1) at 1, the block stays in the start-up window indefinitely. It raises no timeout and ignores triggers.
- R4: The trigger is accepted only on a rising edge of its filtered level, and the raw level must be stable for FILT_CYC cycles. Shorter pulses are ignored, and a falling edge never counts as a service.
- R5: A trigger inside the closed window (the first CLOSE_CYC cycles of a period) adds 1 to fail_cnt, saturating at 7, and restarts the period.
- R6: A trigger inside the open window (the next OPEN_CYC cycles) subtracts 1 from fail_cnt, stopping at 0, and sets first_ok. If the open window ends with no trigger, fail_cnt rises by 1 and a new period starts.
- R7: Writing 1 to control bit 2 sets en_drv only when fail_cnt is at most the threshold (control bits 6:4), first_ok is 1, no status flag is set and the block is in a service period. Writing 0 always clears it.
- R8: When fail_cnt exceeds the threshold, en_drv is cleared, the fail flag (status bit 0) is set and int_n goes low.
- R9: Flags are sticky until a write of 1 to their status bit. A flag whose set condition still holds stays set despite the clear. int_n is low exactly while any flag is set.
- R10: With dis_pin high or control bit 0 at 0, monitoring stops: in_long is 0, fail_cnt and first_ok are 0, en_drv is 0 and triggers have no effect. Returning to monitoring re-enters the start-up window with en_drv still 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_raw | input | 1 | Raw host trigger line |
| dis_pin | input | 1 | High stops monitoring |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| en_drv | output | 1 | Drive-enable output |
| int_n | output | 1 | Active-low interrupt |
| fail_cnt | output | 3 | Current fail count |
| first_ok | output | 1 | At least one good service seen |
| in_long | output | 1 | Block is in the start-up window |

## Verification
Two collisions need care: a flag-clear write that lands in a cycle where the fail count is still above the threshold, and a drive-request write that meets a set flag. The bench pushes the count past the threshold with a run of early triggers, then writes the clear while the count is still high and expects int_n to stay low. After one good service brings the count back to the threshold, it writes a drive request while the flag is still set and expects en_drv to stay 0. A clear followed by a fresh request then has to raise en_drv.

// File: rtl/trig_wdog_pkg.sv
package trig_wdog_pkg;

    localparam int unsigned FAIL_W   = 3;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned TH_LSB   = 4;
    localparam logic [FAIL_W-1:0] FAIL_MAX = '1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;

    localparam int unsigned CB_ON   = 0;
    localparam int unsigned CB_HOLD = 1;
    localparam int unsigned CB_DRV  = 2;
    localparam int unsigned SB_FAIL = 0;
    localparam int unsigned SB_LTO  = 1;
    localparam int unsigned SB_OK   = 2;

    typedef enum logic [1:0] {
        WS_OFF   = 2'd0,
        WS_LONG  = 2'd1,
        WS_CLOSE = 2'd2,
        WS_OPEN  = 2'd3
    } wd_state_e;

endpackage

// File: rtl/trig_wdog_deglitch.sv
module trig_wdog_deglitch #(
    parameter int unsigned FILT_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic rise
);
    localparam int unsigned CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          filt;
        logic [CW-1:0] cnt;
        logic          rise;
    } dg_t;

    dg_t dg_q, dg_d;

    always_comb begin
        dg_d      = dg_q;
        dg_d.sync = {dg_q.sync[0], trig_in};
        dg_d.rise = 1'b0;
        if (dg_q.sync[1] != dg_q.filt) begin
            if (dg_q.cnt == CNT_LAST) begin
                dg_d.filt = dg_q.sync[1];
                dg_d.cnt  = '0;
                dg_d.rise = dg_q.sync[1];
            end else begin
                dg_d.cnt = dg_q.cnt + 1'b1;
            end
        end else begin
            dg_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dg_q <= '0;
        else        dg_q <= dg_d;
    end

    assign rise = dg_q.rise;
endmodule

// File: rtl/trig_wdog_window.sv
module trig_wdog_window
    import trig_wdog_pkg::*;
#(
    parameter int unsigned LONG_CYC  = 772_000_000,
    parameter int unsigned CLOSE_CYC = 10_000,
    parameter int unsigned OPEN_CYC  = 10_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    input  logic svc,
    output logic ev_good,
    output logic ev_bad,
    output logic ev_lto,
    output logic in_long
);
    localparam int unsigned M1  = (LONG_CYC > CLOSE_CYC) ? LONG_CYC : CLOSE_CYC;
    localparam int unsigned MX  = (M1 > OPEN_CYC) ? M1 : OPEN_CYC;
    localparam int unsigned TW  = $clog2(MX + 1);
    localparam logic [TW-1:0] LONG_LAST  = TW'(LONG_CYC - 1);
    localparam logic [TW-1:0] CLOSE_LAST = TW'(CLOSE_CYC - 1);
    localparam logic [TW-1:0] OPEN_LAST  = TW'(OPEN_CYC - 1);

    typedef struct packed {
        wd_state_e     st;
        logic [TW-1:0] tmr;
        logic          good;
        logic          bad;
        logic          lto;
    } win_t;

    win_t w_q, w_d;

    always_comb begin
        w_d      = w_q;
        w_d.good = 1'b0;
        w_d.bad  = 1'b0;
        w_d.lto  = 1'b0;
        if (!run) begin
            w_d.st  = WS_OFF;
            w_d.tmr = '0;
        end else if (hold) begin
            w_d.st  = WS_LONG;
            w_d.tmr = '0;
        end else begin
            unique case (w_q.st)
                WS_OFF: begin
                    w_d.st  = WS_LONG;
                    w_d.tmr = '0;
                end
                WS_LONG: begin
                    if (svc) begin
                        w_d.st  = WS_CLOSE;
                        w_d.tmr = '0;
                    end else if (w_q.tmr == LONG_LAST) begin
                        w_d.st  = WS_CLOSE;
                        w_d.tmr = '0;
                        w_d.bad = 1'b1;
                        w_d.lto = 1'b1;
                    end else begin
                        w_d.tmr = w_q.tmr + 1'b1;
                    end
                end
                WS_CLOSE: begin
                    if (svc) begin
                        w_d.tmr = '0;
                        w_d.bad = 1'b1;
                    end else if (w_q.tmr == CLOSE_LAST) begin
                        w_d.st  = WS_OPEN;
                        w_d.tmr = '0;
                    end else begin
                        w_d.tmr = w_q.tmr + 1'b1;
                    end
                end
                WS_OPEN: begin
                    if (svc) begin
                        w_d.st   = WS_CLOSE;
                        w_d.tmr  = '0;
                        w_d.good = 1'b1;
                    end else if (w_q.tmr == OPEN_LAST) begin
                        w_d.st  = WS_CLOSE;
                        w_d.tmr = '0;
                        w_d.bad = 1'b1;
                    end else begin
                        w_d.tmr = w_q.tmr + 1'b1;
                    end
                end
                default: w_d.st = WS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q     <= '0;
            w_q.st  <= WS_LONG;
        end else begin
            w_q <= w_d;
        end
    end

    assign ev_good = w_q.good;
    assign ev_bad  = w_q.bad;
    assign ev_lto  = w_q.lto;
    assign in_long = (w_q.st == WS_LONG);
endmodule

// File: rtl/trig_wdog_ctrl.sv
module trig_wdog_ctrl
    import trig_wdog_pkg::*;
#(
    parameter logic [FAIL_W-1:0] TH_RST = 3'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              run,
    input  logic              in_long,
    input  logic              ev_good,
    input  logic              ev_bad,
    input  logic              ev_lto,
    output logic              wd_on,
    output logic              hold,
    output logic              en_drv,
    output logic              int_n,
    output logic [FAIL_W-1:0] fail_cnt,
    output logic              first_ok
);
    typedef struct packed {
        logic              wd_on;
        logic              hold;
        logic [FAIL_W-1:0] th;
        logic              drv;
        logic [FAIL_W-1:0] cnt;
        logic              ok;
        logic              f_fail;
        logic              f_lto;
    } ctl_t;

    ctl_t c_q, c_d;
    logic over, permit, wr_ctrl, wr_stat;

    assign wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
    assign wr_stat = reg_we && (reg_addr == ADDR_STAT);
    assign over    = (c_q.cnt > c_q.th);
    assign permit  = !over && c_q.ok && !c_q.f_fail && !c_q.f_lto
                     && run && !in_long && !ev_lto;

    always_comb begin
        c_d = c_q;
        // fail counter and first-good flag
        if (!run) begin
            c_d.cnt = '0;
            c_d.ok  = 1'b0;
        end else if (ev_bad) begin
            if (c_q.cnt != FAIL_MAX) c_d.cnt = c_q.cnt + 1'b1;
        end else if (ev_good) begin
            if (c_q.cnt != '0) c_d.cnt = c_q.cnt - 1'b1;
            c_d.ok = 1'b1;
        end
        // sticky flags: clear first, a live set condition wins
        if (wr_stat) begin
            if (reg_wdata[SB_FAIL]) c_d.f_fail = 1'b0;
            if (reg_wdata[SB_LTO])  c_d.f_lto  = 1'b0;
        end
        if (over)          c_d.f_fail = 1'b1;
        if (ev_lto && run) c_d.f_lto  = 1'b1;
        // control register
        if (wr_ctrl) begin
            c_d.wd_on = reg_wdata[CB_ON];
            c_d.hold  = reg_wdata[CB_HOLD];
            c_d.th    = reg_wdata[TH_LSB +: FAIL_W];
            if (!reg_wdata[CB_DRV]) c_d.drv = 1'b0;
            else if (permit)        c_d.drv = 1'b1;
        end
        if (over || !run || in_long) c_d.drv = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.wd_on <= 1'b1;
            c_q.th    <= TH_RST;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[CB_ON]                = c_q.wd_on;
            reg_rdata[CB_HOLD]              = c_q.hold;
            reg_rdata[CB_DRV]               = c_q.drv;
            reg_rdata[TH_LSB +: FAIL_W]     = c_q.th;
        end else if (reg_addr == ADDR_STAT) begin
            reg_rdata[SB_FAIL]              = c_q.f_fail;
            reg_rdata[SB_LTO]               = c_q.f_lto;
            reg_rdata[SB_OK]                = c_q.ok;
            reg_rdata[TH_LSB +: FAIL_W]     = c_q.cnt;
        end
    end

    assign wd_on    = c_q.wd_on;
    assign hold     = c_q.hold;
    assign en_drv   = c_q.drv;
    assign int_n    = !(c_q.f_fail || c_q.f_lto);
    assign fail_cnt = c_q.cnt;
    assign first_ok = c_q.ok;
endmodule

// File: rtl/trig_wdog.sv
module trig_wdog
    import trig_wdog_pkg::*;
#(
    parameter int unsigned LONG_CYC  = 772_000_000,
    parameter int unsigned CLOSE_CYC = 10_000,
    parameter int unsigned OPEN_CYC  = 10_000,
    parameter int unsigned FILT_CYC  = 30,
    parameter logic [2:0]  TH_RST    = 3'd3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig_raw,
    input  logic         dis_pin,
    input  logic         reg_we,
    input  logic [1:0]   reg_addr,
    input  logic [7:0]   reg_wdata,
    output logic [7:0]   reg_rdata,
    output logic         en_drv,
    output logic         int_n,
    output logic [2:0]   fail_cnt,
    output logic         first_ok,
    output logic         in_long
);
    logic svc, run, wd_on, hold;
    logic ev_good, ev_bad, ev_lto;

    assign run = wd_on && !dis_pin;

    trig_wdog_deglitch #(.FILT_CYC(FILT_CYC)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_raw),
        .rise    (svc)
    );

    trig_wdog_window #(
        .LONG_CYC  (LONG_CYC),
        .CLOSE_CYC (CLOSE_CYC),
        .OPEN_CYC  (OPEN_CYC)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .hold    (hold),
        .svc     (svc),
        .ev_good (ev_good),
        .ev_bad  (ev_bad),
        .ev_lto  (ev_lto),
        .in_long (in_long)
    );

    trig_wdog_ctrl #(.TH_RST(TH_RST)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .run       (run),
        .in_long   (in_long),
        .ev_good   (ev_good),
        .ev_bad    (ev_bad),
        .ev_lto    (ev_lto),
        .wd_on     (wd_on),
        .hold      (hold),
        .en_drv    (en_drv),
        .int_n     (int_n),
        .fail_cnt  (fail_cnt),
        .first_ok  (first_ok)
    );
endmodule

// File: rtl/trig_wdog_chk.sv
module trig_wdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dis_pin,
    input logic       reg_we,
    input logic       en_drv,
    input logic       int_n,
    input logic [2:0] fail_cnt,
    input logic       first_ok,
    input logic       in_long
);
    // drive only rises on a software write with a healthy host
    assert_drv_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_drv) |-> ($past(reg_we) && first_ok && int_n));

    // any pending flag keeps the drive low
    assert_flag_blocks_drv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> !en_drv);

    // start-up window forces drive low
    assert_long_no_drv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_long |=> !en_drv);

    // disable pin drops the drive on the next cycle
    assert_dis_drops_drv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dis_pin |=> !en_drv);

    // fail count moves by one step at most
    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt == $past(fail_cnt)) || (fail_cnt == $past(fail_cnt) + 3'd1)
        || (fail_cnt == $past(fail_cnt) - 3'd1) || (fail_cnt == 3'd0));
endmodule

bind trig_wdog trig_wdog_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dis_pin  (dis_pin),
    .reg_we   (reg_we),
    .en_drv   (en_drv),
    .int_n    (int_n),
    .fail_cnt (fail_cnt),
    .first_ok (first_ok),
    .in_long  (in_long)
);

// File: tb/trig_wdog_tb.sv
module trig_wdog_tb;
    localparam int unsigned LONG_C  = 200;
    localparam int unsigned CLOSE_C = 40;
    localparam int unsigned OPEN_C  = 40;
    localparam int unsigned FILT_C  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_raw = 1'b0;
    logic       dis_pin = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       en_drv, int_n, first_ok, in_long;
    logic [2:0] fail_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trig_wdog #(
        .LONG_CYC(LONG_C), .CLOSE_CYC(CLOSE_C), .OPEN_CYC(OPEN_C),
        .FILT_CYC(FILT_C), .TH_RST(3'd3)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_raw(trig_raw), .dis_pin(dis_pin),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .en_drv(en_drv), .int_n(int_n),
        .fail_cnt(fail_cnt), .first_ok(first_ok), .in_long(in_long)
    );

    // {gap before trigger, drive request, exp cnt, exp first_ok, exp drv, exp int_n, pad}
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        {8'd44, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'd4,  1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'd4,  1'b0, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'd44, 1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'd4,  1'b0, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'd4,  1'b0, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'd4,  1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'd44, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] dat);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = dat;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] dat);
        @(negedge clk);
        reg_addr = a;
        #1 dat = reg_rdata;
    endtask

    // wait gap, raise trigger for 10 cycles, drop it, settle 4 cycles
    task automatic pulse(input int gap);
        cyc(gap);
        trig_raw = 1'b1;
        cyc(10);
        trig_raw = 1'b0;
        cyc(4);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; trig_raw = 1'b0; dis_pin = 1'b0; reg_we = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog timer expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        do_reset();
        // R1 reset state
        chk("R1 en_drv", en_drv, 0);
        chk("R1 int_n", int_n, 1);
        chk("R1 fail_cnt", fail_cnt, 0);
        chk("R1 first_ok", first_ok, 0);
        chk("R1 in_long", in_long, 1);

        // R2 drive request ignored in start-up window
        wr(2'd0, 8'h35);
        cyc(2);
        chk("R2 drv in long window", en_drv, 0);

        // leave the long window with one trigger
        pulse(20);
        chk("R2 left long window", in_long, 0);
        chk("R2 no count on entry", fail_cnt, 0);

        // table walk: R4 falling edges inside closed windows do not count,
        // R5 early triggers, R6 open-window triggers, R7/R8 drive gating
        for (int i = 0; i < NV; i++) begin
            pulse(int'(VEC[i][15:8]));
            if (VEC[i][7]) wr(2'd0, 8'h35);
            cyc(1);
            chk($sformatf("R5 R6 cnt vec%0d", i), fail_cnt, int'(VEC[i][6:4]));
            chk($sformatf("R6 first_ok vec%0d", i), first_ok, int'(VEC[i][3]));
            chk($sformatf("R7 R8 en_drv vec%0d", i), en_drv, int'(VEC[i][2]));
            chk($sformatf("R8 int_n vec%0d", i), int_n, int'(VEC[i][1]));
            if (i == 6) begin
                // R9 clear collides with live over-threshold condition
                wr(2'd1, 8'h01);
                cyc(1);
                chk("R9 clear loses to live set", int_n, 0);
            end
        end

        // R9 clear works once the count is back at the threshold
        wr(2'd1, 8'h01);
        cyc(1);
        chk("R9 flag cleared", int_n, 1);
        rd(2'd1, rv);
        chk("R9 status fail bit", rv[0], 0);
        // R7 request accepted now
        wr(2'd0, 8'h35);
        cyc(1);
        chk("R7 drv set after clear", en_drv, 1);

        // R6 open window expiry counts a failure, R8 pushes past threshold
        cyc(75);
        chk("R6 expiry cnt", fail_cnt, 4);
        chk("R8 drv forced low", en_drv, 0);
        chk("R8 int_n low", int_n, 0);

        // R4 short glitch inside closed window is ignored
        trig_raw = 1'b1; cyc(2); trig_raw = 1'b0;
        cyc(8);
        chk("R4 glitch ignored", fail_cnt, 4);

        // R10 disable pin stops monitoring
        dis_pin = 1'b1;
        cyc(3);
        chk("R10 cnt cleared", fail_cnt, 0);
        chk("R10 first_ok cleared", first_ok, 0);
        chk("R10 not in long", in_long, 0);
        pulse(2);
        pulse(2);
        chk("R10 triggers ignored", fail_cnt, 0);
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h35);
        cyc(1);
        chk("R10 drv stays low", en_drv, 0);
        dis_pin = 1'b0;
        cyc(3);
        chk("R10 back in long window", in_long, 1);
        chk("R10 enabling keeps drv low", en_drv, 0);
        // R10 register enable bit cleared
        wr(2'd0, 8'h30);
        cyc(2);
        chk("R10 ctrl off", in_long, 0);

        // R2 start-up window timeout
        do_reset();
        cyc(LONG_C + 20);
        chk("R2 timeout leaves long", in_long, 0);
        chk("R2 timeout cnt", fail_cnt, 1);
        chk("R2 timeout int_n", int_n, 0);
        rd(2'd1, rv);
        chk("R2 timeout flag bit1", rv[1], 1);
        wr(2'd1, 8'h02);
        cyc(1);
        chk("R9 timeout flag cleared", int_n, 1);

        // R3 hold parks in long window
        do_reset();
        wr(2'd0, 8'h33);
        cyc(LONG_C + 100);
        chk("R3 still long", in_long, 1);
        chk("R3 no timeout", int_n, 1);
        pulse(5);
        chk("R3 trigger ignored", in_long, 1);
        chk("R3 cnt", fail_cnt, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule